// File: doc/BRIEF.md
# Two-Wire Interface Control and Handshake Register

This block is the register that software uses to steer a two-wire serial bus controller. It holds the enable bit and the interrupt-enable bit. It also holds the acknowledge-enable bit and the requests to send a START or a STOP condition. An interrupt flag is set by the bus engine when a job finishes. A write-collision flag catches data-register writes made at the wrong moment.

Software reads and writes the register over a simple register bus. The interrupt flag is cleared by writing a one to it, and that write also hands the next job to the bus engine as a one-cycle `eng_go` pulse. While the flag is set and the interface is enabled, `eng_hold` tells the engine to keep the clock line low, which stretches the bus until software responds. The shift engine and the pin drivers sit outside this block.

The data register itself lives elsewhere. This block only watches writes to its address so that it can raise the collision flag.

Top module: `twi_ctrl_reg`

## Requirements
- R1: A read at the control address returns the flag in bit 7, acknowledge-enable in bit 6, START request in bit 5, STOP request in bit 4, write-collision in bit 3, enable in bit 2, zero in bit 1 and interrupt-enable in bit 0.
- R2: After reset every bit reads 0. A control write never changes the write-collision bit.
- R3: A cycle with `eng_done` high sets the interrupt flag at the next edge. This holds even when a clearing write arrives in the same cycle.
- R4: A control write with bit 7 = 1 clears the interrupt flag. A control write with bit 7 = 0 leaves the flag unchanged.
- R5: A control write with bit 7 = 1 and bit 2 = 1 produces a single `eng_go` pulse in the cycle after the write, unless `eng_done` is high in the write cycle.
- R6: `eng_hold` is high exactly when the flag and the enable bit are both set, as registered at the same edge.
- R7: `irq` is high in the cycle after an edge at which the flag and interrupt-enable are both set and `gie` was high.
- R8: A write to the data address while the flag is 0 sets the write-collision bit. Such a write while the flag is 1 clears it.
- R9: `eng_start_req`, `eng_stop_req` and `eng_ack_en` show their register bits gated by enable.
- R10: `eng_start_sent` clears the START bit and `eng_stop_sent` clears the STOP bit, unless a control write in the same cycle loads that bit.
- R11: With enable written 0, no `eng_go` is issued and `eng_hold` stays low, even while the flag is set.
- R12: `bus_rdata` is registered. It reflects the address and the register state sampled at the previous edge, and any address other than the control address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| gie | input | 1 | Global interrupt enable |
| eng_done | input | 1 | Engine finished its current job |
| eng_start_sent | input | 1 | Engine has sent the START condition |
| eng_stop_sent | input | 1 | Engine has sent the STOP condition |
| eng_go | output | 1 | One-cycle pulse that starts the next job |
| eng_hold | output | 1 | Keep the clock line low |
| eng_ack_en | output | 1 | Acknowledge received bytes |
| eng_start_req | output | 1 | START condition requested |
| eng_stop_req | output | 1 | STOP condition requested |
| irq | output | 1 | Interrupt request |

## Verification
Every result is due exactly one clock after the stimulus that causes it:
- the flag and collision state, `eng_go`, `eng_hold` and `irq` all update at the edge that samples the write or `eng_done`;
- the request outputs follow the bits stored at that edge;
- `bus_rdata` shows the state from before that same edge.

The bench drives its inputs on the falling edge. A behavioural model updates at each rising edge from those inputs, and all outputs are compared at the next falling edge. Each comparison is therefore made one cycle after the stimulus, never in the same cycle. Targeted sequences cover the same-cycle collisions between `eng_done` and a clearing write, and between an engine clear and a software load. Pseudo-random traffic follows them.

// File: rtl/twi_ctrl_pkg.sv
package twi_ctrl_pkg;
  localparam int REG_W  = 8;
  localparam int B_FLAG = 7;
  localparam int B_ACK  = 6;
  localparam int B_STA  = 5;
  localparam int B_STO  = 4;
  localparam int B_WC   = 3;
  localparam int B_EN   = 2;
  localparam int B_IE   = 0;

  typedef struct packed {
    logic ack;
    logic sta;
    logic sto;
    logic en;
    logic ie;
  } ctl_t;

  function automatic logic [REG_W-1:0] reg_view(input logic flag, input logic wc, input ctl_t c);
    logic [REG_W-1:0] v;
    v         = '0;
    v[B_FLAG] = flag;
    v[B_ACK]  = c.ack;
    v[B_STA]  = c.sta;
    v[B_STO]  = c.sto;
    v[B_WC]   = wc;
    v[B_EN]   = c.en;
    v[B_IE]   = c.ie;
    return v;
  endfunction
endpackage

// File: rtl/twi_ctrl_bits.sv
module twi_ctrl_bits
  import twi_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             start_sent,
  input  logic             stop_sent,
  output ctl_t             ctl_n,
  output ctl_t             ctl_q
);
  always_comb begin
    ctl_n = ctl_q;
    if (ctl_wr) begin
      ctl_n.ack = wdata[B_ACK];
      ctl_n.sta = wdata[B_STA];
      ctl_n.sto = wdata[B_STO];
      ctl_n.en  = wdata[B_EN];
      ctl_n.ie  = wdata[B_IE];
    end else begin
      if (start_sent) ctl_n.sta = 1'b0;
      if (stop_sent)  ctl_n.sto = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_n;
  end
endmodule

// File: rtl/twi_ctrl_flag.sv
module twi_ctrl_flag
  import twi_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             data_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             eng_done,
  output logic             flag_n,
  output logic             flag_q,
  output logic             wc_q,
  output logic             go_q
);
  logic clear_req;
  logic go_n;
  logic wc_n;

  assign clear_req = ctl_wr & wdata[B_FLAG];

  always_comb begin
    if (eng_done)       flag_n = 1'b1;
    else if (clear_req) flag_n = 1'b0;
    else                flag_n = flag_q;
  end

  assign go_n = clear_req & wdata[B_EN] & ~eng_done;
  assign wc_n = data_wr ? ~flag_q : wc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      wc_q   <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      flag_q <= flag_n;
      wc_q   <= wc_n;
      go_q   <= go_n;
    end
  end
endmodule

// File: rtl/twi_ctrl_out.sv
module twi_ctrl_out
  import twi_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_ctl,
  input  logic             gie,
  input  logic             flag_n,
  input  ctl_t             ctl_n,
  input  logic             flag_q,
  input  logic             wc_q,
  input  ctl_t             ctl_q,
  output logic             hold_q,
  output logic             irq_q,
  output logic [REG_W-1:0] rdata_q
);
  logic [REG_W-1:0] view;

  assign view = reg_view(flag_q, wc_q, ctl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      hold_q  <= flag_n & ctl_n.en;
      irq_q   <= flag_n & ctl_n.ie & gie;
      rdata_q <= rd_ctl ? view : '0;
    end
  end
endmodule

// File: rtl/twi_ctrl_reg.sv
module twi_ctrl_reg
  import twi_ctrl_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              gie,
  input  logic              eng_done,
  input  logic              eng_start_sent,
  input  logic              eng_stop_sent,
  output logic              eng_go,
  output logic              eng_hold,
  output logic              eng_ack_en,
  output logic              eng_start_req,
  output logic              eng_stop_req,
  output logic              irq
);
  logic ctl_wr, data_wr, rd_ctl;
  logic flag_n, flag_q, wc_q, go_q, hold_q, irq_q;
  logic en_q, ie_q;
  ctl_t ctl_n, ctl_q;

  assign rd_ctl  = (bus_addr == CTRL_ADDR);
  assign ctl_wr  = bus_we & rd_ctl;
  assign data_wr = bus_we & (bus_addr == DATA_ADDR);

  twi_ctrl_bits u_bits (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(bus_wdata),
    .start_sent(eng_start_sent), .stop_sent(eng_stop_sent),
    .ctl_n(ctl_n), .ctl_q(ctl_q)
  );

  twi_ctrl_flag u_flag (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .data_wr(data_wr),
    .wdata(bus_wdata), .eng_done(eng_done), .flag_n(flag_n),
    .flag_q(flag_q), .wc_q(wc_q), .go_q(go_q)
  );

  twi_ctrl_out u_out (
    .clk(clk), .rst(rst), .rd_ctl(rd_ctl), .gie(gie), .flag_n(flag_n),
    .ctl_n(ctl_n), .flag_q(flag_q), .wc_q(wc_q), .ctl_q(ctl_q),
    .hold_q(hold_q), .irq_q(irq_q), .rdata_q(bus_rdata)
  );

  assign en_q          = ctl_q.en;
  assign ie_q          = ctl_q.ie;
  assign eng_go        = go_q;
  assign eng_hold      = hold_q;
  assign irq           = irq_q;
  assign eng_ack_en    = ctl_q.ack & ctl_q.en;
  assign eng_start_req = ctl_q.sta & ctl_q.en;
  assign eng_stop_req  = ctl_q.sto & ctl_q.en;
endmodule

// File: rtl/twi_ctrl_reg_chk.sv
module twi_ctrl_reg_chk #(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              eng_done,
  input logic              eng_go,
  input logic              eng_hold,
  input logic              irq,
  input logic              flag_q,
  input logic              wc_q,
  input logic              en_q,
  input logic              ie_q
);
  logic cw, dw;
  assign cw = bus_we && (bus_addr == CTRL_ADDR);
  assign dw = bus_we && (bus_addr == DATA_ADDR);

  p_done_sets_r3: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> flag_q);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (cw && bus_wdata[7] && !eng_done) |=> !flag_q);
  p_go_src_r5: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> $past(cw && bus_wdata[7] && bus_wdata[2] && !eng_done));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    eng_hold == (flag_q && en_q));
  p_irq_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_q && ie_q));
  p_wc_set_r8: assert property (@(posedge clk) disable iff (rst)
    (dw && !flag_q) |=> wc_q);
  p_wc_ro_r2: assert property (@(posedge clk) disable iff (rst)
    (cw && !dw) |=> $stable(wc_q));
  p_no_go_off_r11: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> en_q);
endmodule

bind twi_ctrl_reg twi_ctrl_reg_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .eng_done(eng_done), .eng_go(eng_go),
  .eng_hold(eng_hold), .irq(irq), .flag_q(flag_q), .wc_q(wc_q),
  .en_q(en_q), .ie_q(ie_q)
);

// File: tb/twi_ctrl_reg_tb.sv
module twi_ctrl_reg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       gie = 1'b0, eng_done = 1'b0, eng_start_sent = 1'b0, eng_stop_sent = 1'b0;
  logic       eng_go, eng_hold, eng_ack_en, eng_start_req, eng_stop_req, irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  twi_ctrl_reg u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .eng_done(eng_done), .eng_start_sent(eng_start_sent),
    .eng_stop_sent(eng_stop_sent), .eng_go(eng_go), .eng_hold(eng_hold),
    .eng_ack_en(eng_ack_en), .eng_start_req(eng_start_req),
    .eng_stop_req(eng_stop_req), .irq(irq)
  );

  // behavioural reference model
  bit m_flag, m_ack, m_sta, m_sto, m_wc, m_en, m_ie, m_go, m_hold, m_irq;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    bit cw, dw, oflag;
    if (rst) begin
      {m_flag, m_ack, m_sta, m_sto, m_wc, m_en, m_ie, m_go, m_hold, m_irq} = '0;
      m_rd = 8'h00;
    end else begin
      cw    = bus_we && bus_addr == 4'd0;
      dw    = bus_we && bus_addr == 4'd1;
      oflag = m_flag;
      m_rd  = (bus_addr == 4'd0) ?
              {m_flag, m_ack, m_sta, m_sto, m_wc, m_en, 1'b0, m_ie} : 8'h00;
      m_go  = cw && bus_wdata[7] && bus_wdata[2] && !eng_done;
      if (eng_done)                m_flag = 1;
      else if (cw && bus_wdata[7]) m_flag = 0;
      if (cw) begin
        m_ack = bus_wdata[6]; m_sta = bus_wdata[5]; m_sto = bus_wdata[4];
        m_en  = bus_wdata[2]; m_ie  = bus_wdata[0];
      end else begin
        if (eng_start_sent) m_sta = 0;
        if (eng_stop_sent)  m_sto = 0;
      end
      if (dw) m_wc = !oflag;
      m_hold = m_flag && m_en;
      m_irq  = m_flag && m_ie && gie;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1/R12 rdata", bus_rdata, m_rd);
      chk("R5 go", {7'd0, eng_go}, {7'd0, m_go});
      chk("R6 hold", {7'd0, eng_hold}, {7'd0, m_hold});
      chk("R7 irq", {7'd0, irq}, {7'd0, m_irq});
      chk("R9 req", {5'd0, eng_ack_en, eng_start_req, eng_stop_req},
          {5'd0, m_ack && m_en, m_sta && m_en, m_sto && m_en});
    end
  end

  task automatic cyc(input bit we, input logic [3:0] a, input logic [7:0] d,
                     input bit dn = 0, input bit ss = 0, input bit ps = 0);
    bus_we = we; bus_addr = a; bus_wdata = d;
    eng_done = dn; eng_start_sent = ss; eng_stop_sent = ps;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 0;
    cyc(0, 0, 0);
    chk("R2 reset", bus_rdata, 8'h00);
    // R5: start job with enable, START and clear
    cyc(1, 0, 8'hA5);
    chk("R5 go pulse", {7'd0, eng_go}, 8'd1);
    cyc(0, 0, 0);
    chk("R5 single pulse", {7'd0, eng_go}, 8'd0);
    chk("R1 view", bus_rdata, 8'h25);
    // R10 start cleared by engine
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0);
    chk("R10 start cleared", bus_rdata, 8'h05);
    // R3 done sets flag, R6 hold, R7 irq
    gie = 1;
    cyc(0, 0, 0, 1);
    chk("R6 hold set", {7'd0, eng_hold}, 8'd1);
    chk("R7 irq set", {7'd0, irq}, 8'd1);
    // R8 collision cleared with flag high, R4 write 0 keeps flag
    cyc(1, 1, 8'h55);
    cyc(1, 0, 8'h45);
    cyc(0, 0, 0);
    chk("R4 write zero keeps flag", bus_rdata, 8'hC5);
    // R3 done wins over clear
    cyc(1, 0, 8'hC5, 1);
    chk("R3 no go on collide", {7'd0, eng_go}, 8'd0);
    // R4 clear
    cyc(1, 0, 8'h84);
    cyc(0, 0, 0);
    chk("R4 cleared", bus_rdata, 8'h04);
    // R8 collision set, R2 read-only
    cyc(1, 1, 8'h00);
    cyc(1, 0, 8'h04);
    cyc(0, 0, 0);
    chk("R8 R2 wc kept", bus_rdata, 8'h0C);
    // R11 disabled: no go, no hold
    cyc(1, 0, 8'h80);
    chk("R11 no go", {7'd0, eng_go}, 8'd0);
    cyc(0, 0, 0, 1);
    chk("R11 no hold", {7'd0, eng_hold}, 8'd0);
    // R10 write beats stop clear
    cyc(1, 0, 8'h14, 0, 0, 1);
    cyc(0, 0, 0);
    chk("R10 load wins", {7'd0, eng_stop_req}, 8'd1);
    // R12 other address reads zero
    cyc(0, 4'd7, 0);
    cyc(0, 4'd7, 0);
    chk("R12 other addr", bus_rdata, 8'h00);
    // pseudo-random traffic compared by the model every cycle
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      gie = lf[3];
      cyc(lf[0] | lf[9], {2'b00, lf[2:1] == 2'b11 ? 2'd2 : {1'b0, lf[1]}},
          lf[15:8], lf[4] & lf[5], lf[6], lf[7]);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule